// File: doc/BRIEF.md
# Sixteen-Level Interrupt Priority Masker

This block decides which external interrupt request, if any, the processor should take as an asynchronous trap. Fifteen request lines stand for priority levels 1 to 15. Level 0 means "no request". A request is compared against the processor's current interrupt level and against a global trap-enable bit. The highest request that passes is presented on a registered output together with its trap-type code.

Level 15 is non-maskable: the current level never blocks it. It still obeys the trap-enable bit. A second stage accepts up to sixteen further sources, numbered 16 to 31. Any of them raises one shared, configurable level. The lowest-numbered source that fires is latched into an identifier register, which software reads. The register holds its value until software clears it with a one-cycle acknowledge strobe.

All decision outputs are registered, so a change on any input appears on the outputs one clock later. The block only reports a decision. Trap entry and acknowledgement back to the sources are handled elsewhere. The outputs are plain control and status pins with no handshake: they are rewritten on every clock and no back-pressure is involved.

Top module: `irq_prio_mask`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `irq_valid`, `irq_level`, `irq_tt`, `ext_vld` and `ext_src` are all zero.
- R2: Outputs are registered. Inputs sampled at one rising clock edge determine the outputs that follow that edge, and the outputs do not change between edges.
- R3: Request bit `irq_req[n-1]` stands for level n. A level n below 15 is taken only when n is strictly greater than `cur_level`. When `cur_level` is 0, every level from 1 to 15 can be taken.
- R4: With `trap_en` high, a level-15 request is taken for every value of `cur_level`, including 15.
- R5: With `trap_en` low, no request is taken (`irq_valid` = 0), level 15 included.
- R6: When several eligible requests are pending, the highest level is the one reported.
- R7: When a request is taken, `irq_tt` = 0x10 + `irq_level`. When none is taken, `irq_valid`, `irq_level` and `irq_tt` are all 0.
- R8: When any `ext_req` bit is set and `ext_level` is in 1..14, level `ext_level` is requested. An `ext_level` of 0 or 15 disables this shared request.
- R9: When the identifier register is empty and any extended source is pending, it latches `ext_src` = 16 + the lowest set `ext_req` bit index, and `ext_vld` rises. While it is full it keeps its value, whatever the sources do.
- R10: An `ext_ack` pulse empties the identifier register on the next edge. The acknowledge wins over a capture in the same cycle. If sources are still pending, the lowest one is captured on the following edge.
- R11: The shared level stays requested for as long as any extended source is pending, whatever the state of the identifier register or `ext_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 15 | Request per level; bit n-1 is level n |
| cur_level | input | 4 | Current processor interrupt level |
| trap_en | input | 1 | Global trap enable |
| ext_req | input | 16 | Extended sources 16..31; bit k is source 16+k |
| ext_level | input | 4 | Shared level raised by extended sources (1..14 active) |
| ext_ack | input | 1 | Software acknowledge; clears the identifier register |
| irq_valid | output | 1 | A request is to be taken |
| irq_level | output | 4 | Level of the request taken, 0 if none |
| irq_tt | output | 8 | Trap-type code of the request taken, 0 if none |
| ext_vld | output | 1 | Identifier register holds a source |
| ext_src | output | 5 | Latched extended source number (16..31) |

## Verification
The hardest case to reach from the ports is the identifier register being acknowledged while several extended sources are still pending. In that case the acknowledge must beat a recapture in the same cycle, and the next lowest source must follow one cycle later, while the shared level stays asserted throughout. The directed phase builds this on purpose: it changes the pending set while the register is full, then pulses the acknowledge. A long random phase follows, with acknowledges at random times and changing `ext_level` values. It is compared against a behavioural model on every clock, and reaches the same case at different offsets relative to the sources changing.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  // Default geometry shared by the masker and its bench
  localparam int DEF_NUM_LEVELS = 16;
  localparam int DEF_EXT_SRCS   = 16;
  localparam int DEF_TT_W       = 8;
  localparam int DEF_TT_BASE    = 16;

  // Selects whether the extended-source fold stage is built
  typedef enum logic {
    FOLD_OFF = 1'b0,
    FOLD_ON  = 1'b1
  } fold_mode_e;
endpackage

// File: rtl/irqm_ext_fold.sv
module irqm_ext_fold #(
  parameter int EXT_SRCS = 16,
  parameter int LVL_W    = 4,
  parameter int REQ_W    = 15,
  parameter int SRC_BASE = 16,
  parameter int ID_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EXT_SRCS-1:0] ext_req,
  input  logic [LVL_W-1:0]    ext_level,
  input  logic                ext_ack,
  output logic [REQ_W-1:0]    fold_vec,
  output logic                ext_vld,
  output logic [ID_W-1:0]     ext_src
);
  localparam int IDX_W = (EXT_SRCS > 1) ? $clog2(EXT_SRCS) : 1;

  logic             any_ext;
  logic [IDX_W-1:0] low_idx;

  assign any_ext = |ext_req;

  // Lowest-numbered pending source: scan downward so the last hit wins
  always_comb begin
    low_idx = '0;
    for (int i = EXT_SRCS - 1; i >= 0; i--) begin
      if (ext_req[i]) low_idx = IDX_W'(i);
    end
  end

  // Shared level: only levels 1..REQ_W-1 may be the fold target
  for (genvar j = 0; j < REQ_W; j++) begin : g_fold
    if (j < REQ_W - 1) begin : g_act
      assign fold_vec[j] = any_ext && (ext_level == LVL_W'(j + 1));
    end else begin : g_top
      assign fold_vec[j] = 1'b0;
    end
  end

  // Identifier register: capture when empty, hold until acknowledged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_vld <= 1'b0;
      ext_src <= '0;
    end else if (ext_ack) begin
      ext_vld <= 1'b0;
      ext_src <= '0;
    end else if (!ext_vld && any_ext) begin
      ext_vld <= 1'b1;
      ext_src <= ID_W'(SRC_BASE) + ID_W'(low_idx);
    end
  end
endmodule

// File: rtl/irqm_mask.sv
module irqm_mask #(
  parameter int LVL_W = 4,
  parameter int REQ_W = 15
) (
  input  logic [REQ_W-1:0] req_vec,
  input  logic [LVL_W-1:0] cur_level,
  input  logic             trap_en,
  output logic             take,
  output logic [LVL_W-1:0] take_level
);
  logic [REQ_W-1:0] eligible;

  // Top level ignores the current level; all obey trap enable
  for (genvar j = 0; j < REQ_W; j++) begin : g_elig
    if (j == REQ_W - 1) begin : g_nmi
      assign eligible[j] = trap_en && req_vec[j];
    end else begin : g_mask
      assign eligible[j] = trap_en && req_vec[j] && (int'(cur_level) < j + 1);
    end
  end

  // Highest eligible level: scan upward so the last hit wins
  always_comb begin
    take_level = '0;
    for (int j = 0; j < REQ_W; j++) begin
      if (eligible[j]) take_level = LVL_W'(j + 1);
    end
  end

  assign take = |eligible;
endmodule

// File: rtl/irqm_out_reg.sv
module irqm_out_reg #(
  parameter int LVL_W   = 4,
  parameter int TT_W    = 8,
  parameter int TT_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LVL_W-1:0] take_level,
  output logic             irq_valid,
  output logic [LVL_W-1:0] irq_level,
  output logic [TT_W-1:0]  irq_tt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_tt    <= '0;
    end else if (take) begin
      irq_valid <= 1'b1;
      irq_level <= take_level;
      irq_tt    <= TT_W'(TT_BASE) + TT_W'(take_level);
    end else begin
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_tt    <= '0;
    end
  end
endmodule

// File: rtl/irq_prio_mask.sv
module irq_prio_mask
  import irqm_pkg::*;
#(
  parameter int         NUM_LEVELS = DEF_NUM_LEVELS,
  parameter int         EXT_SRCS   = DEF_EXT_SRCS,
  parameter int         TT_W       = DEF_TT_W,
  parameter int         TT_BASE    = DEF_TT_BASE,
  parameter fold_mode_e FOLD       = FOLD_ON,
  localparam int        LVL_W      = $clog2(NUM_LEVELS),
  localparam int        REQ_W      = NUM_LEVELS - 1,
  localparam int        ID_W       = $clog2(NUM_LEVELS + EXT_SRCS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REQ_W-1:0]    irq_req,
  input  logic [LVL_W-1:0]    cur_level,
  input  logic                trap_en,
  input  logic [EXT_SRCS-1:0] ext_req,
  input  logic [LVL_W-1:0]    ext_level,
  input  logic                ext_ack,
  output logic                irq_valid,
  output logic [LVL_W-1:0]    irq_level,
  output logic [TT_W-1:0]     irq_tt,
  output logic                ext_vld,
  output logic [ID_W-1:0]     ext_src
);
  logic [REQ_W-1:0] fold_vec;
  logic [REQ_W-1:0] req_vec;
  logic             take;
  logic [LVL_W-1:0] take_level;

  if (FOLD == FOLD_ON) begin : g_ext
    irqm_ext_fold #(
      .EXT_SRCS (EXT_SRCS),
      .LVL_W    (LVL_W),
      .REQ_W    (REQ_W),
      .SRC_BASE (NUM_LEVELS),
      .ID_W     (ID_W)
    ) u_fold (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_req   (ext_req),
      .ext_level (ext_level),
      .ext_ack   (ext_ack),
      .fold_vec  (fold_vec),
      .ext_vld   (ext_vld),
      .ext_src   (ext_src)
    );
  end else begin : g_noext
    assign fold_vec = '0;
    assign ext_vld  = 1'b0;
    assign ext_src  = '0;
  end

  assign req_vec = irq_req | fold_vec;

  irqm_mask #(
    .LVL_W (LVL_W),
    .REQ_W (REQ_W)
  ) u_mask (
    .req_vec    (req_vec),
    .cur_level  (cur_level),
    .trap_en    (trap_en),
    .take       (take),
    .take_level (take_level)
  );

  irqm_out_reg #(
    .LVL_W   (LVL_W),
    .TT_W    (TT_W),
    .TT_BASE (TT_BASE)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_level (take_level),
    .irq_valid  (irq_valid),
    .irq_level  (irq_level),
    .irq_tt     (irq_tt)
  );
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int LVL_W    = 4,
  parameter int REQ_W    = 15,
  parameter int EXT_SRCS = 16,
  parameter int TT_W     = 8,
  parameter int TT_BASE  = 16,
  parameter int ID_W     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [REQ_W-1:0]    irq_req,
  input logic [LVL_W-1:0]    cur_level,
  input logic                trap_en,
  input logic [EXT_SRCS-1:0] ext_req,
  input logic                ext_ack,
  input logic                irq_valid,
  input logic [LVL_W-1:0]    irq_level,
  input logic [TT_W-1:0]     irq_tt,
  input logic                ext_vld,
  input logic [ID_W-1:0]     ext_src
);
  // R5
  no_take_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |=> !irq_valid);

  // R4
  top_level_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en && irq_req[REQ_W-1]) |=> (irq_valid && irq_level == LVL_W'(REQ_W)));

  // R3
  above_current_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level != LVL_W'(REQ_W)) |-> (irq_level > $past(cur_level)));

  // R7
  trap_code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_tt == TT_W'(TT_BASE) + TT_W'(irq_level)));

  // R7
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_level == '0 && irq_tt == '0));

  // R9
  id_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_vld && !ext_ack) |=> (ext_vld && $stable(ext_src)));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> !ext_vld);

  // R9
  capture_on_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_vld && !ext_ack && (|ext_req)) |=> ext_vld);
endmodule

bind irq_prio_mask irqm_chk #(
  .LVL_W    (LVL_W),
  .REQ_W    (REQ_W),
  .EXT_SRCS (EXT_SRCS),
  .TT_W     (TT_W),
  .TT_BASE  (TT_BASE),
  .ID_W     (ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .cur_level (cur_level),
  .trap_en   (trap_en),
  .ext_req   (ext_req),
  .ext_ack   (ext_ack),
  .irq_valid (irq_valid),
  .irq_level (irq_level),
  .irq_tt    (irq_tt),
  .ext_vld   (ext_vld),
  .ext_src   (ext_src)
);

// File: tb/tb_irq_prio_mask.sv
module tb_irq_prio_mask;
  localparam int LW = 4;
  localparam int RW = 15;
  localparam int ES = 16;
  localparam int TW = 8;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] irq_req;
  logic [LW-1:0] cur_level;
  logic          trap_en;
  logic [ES-1:0] ext_req;
  logic [LW-1:0] ext_level;
  logic          ext_ack;
  logic          irq_valid;
  logic [LW-1:0] irq_level;
  logic [TW-1:0] irq_tt;
  logic          ext_vld;
  logic [IW-1:0] ext_src;

  always #10 clk = ~clk;

  irq_prio_mask dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cur_level(cur_level),
    .trap_en(trap_en), .ext_req(ext_req), .ext_level(ext_level),
    .ext_ack(ext_ack), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_tt(irq_tt), .ext_vld(ext_vld), .ext_src(ext_src)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural reference state
  int m_valid, m_level, m_tt, m_evld, m_esrc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_level = 0; m_tt = 0; m_evld = 0; m_esrc = 0;
    end else begin
      int best, low;
      bit any;
      any  = (ext_req != 0);
      low  = -1;
      for (int k = ES - 1; k >= 0; k--) if (ext_req[k]) low = k;
      best = 0;
      for (int l = 1; l <= RW; l++) begin
        bit r;
        r = irq_req[l-1] || (any && int'(ext_level) == l && l <= RW - 1);
        if (r && trap_en && (l == RW || l > int'(cur_level))) best = l;
      end
      m_valid = (best != 0) ? 1 : 0;
      m_level = best;
      m_tt    = (best != 0) ? 16 + best : 0;
      if (ext_ack) begin
        m_evld = 0; m_esrc = 0;
      end else if (m_evld == 0 && any) begin
        m_evld = 1; m_esrc = 16 + low;
      end
    end
  end

  task automatic xchk(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Compare against the model; field groups map to requirements
  task automatic cmp();
    xchk("R6 valid", int'(irq_valid), m_valid);
    xchk("R6 level", int'(irq_level), m_level);
    xchk("R7 tt", int'(irq_tt), m_tt);
    xchk("R9 ext_vld", int'(ext_vld), m_evld);
    xchk("R9 ext_src", int'(ext_src), m_esrc);
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; irq_req = '0; cur_level = '0; trap_en = 1'b1;
    ext_req = '0; ext_level = 4'd7; ext_ack = 1'b0;
    irq_req = 15'h7fff; ext_req = 16'hffff;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset even with requests pending
    xchk("R1 valid", int'(irq_valid), 0);
    xchk("R1 tt", int'(irq_tt), 0);
    xchk("R1 ext_vld", int'(ext_vld), 0);
    irq_req = '0; ext_req = '0;
    rst_n = 1;
    step();
    xchk("R1 post-reset level", int'(irq_level), 0);

    // R3: level 5 with varying current level
    irq_req = 15'(1 << 4); cur_level = 4'd0;
    step();
    xchk("R3 level0 enables all", int'(irq_level), 5);
    xchk("R7 code", int'(irq_tt), 8'h15);
    cur_level = 4'd5;
    step();
    xchk("R3 equal blocked", int'(irq_valid), 0);
    cur_level = 4'd4;
    step();
    xchk("R3 above taken", int'(irq_level), 5);

    // R2: change at negedge is not visible until the next edge
    irq_req = 15'(1 << 8);
    #1 xchk("R2 before edge", int'(irq_level), 5);
    step();
    xchk("R2 after edge", int'(irq_level), 9);

    // R4: non-maskable top level at current level 15
    cur_level = 4'd15; irq_req = 15'h7fff;
    step();
    xchk("R4 top taken", int'(irq_level), 15);
    xchk("R7 top code", int'(irq_tt), 8'h1f);

    // R5: trap enable low blocks everything
    trap_en = 1'b0;
    step();
    xchk("R5 disabled", int'(irq_valid), 0);
    trap_en = 1'b1;

    // R6: several pending, highest eligible wins
    irq_req = 15'(1 << 2) | 15'(1 << 8) | 15'(1 << 11); cur_level = 4'd2;
    step();
    xchk("R6 highest", int'(irq_level), 12);
    cur_level = 4'd12;
    step();
    xchk("R6 all blocked", int'(irq_valid), 0);

    // R8: extended sources fold onto the shared level
    irq_req = '0; cur_level = 4'd0; ext_level = 4'd7; ext_req = 16'(1 << 3);
    step();
    xchk("R8 shared level", int'(irq_level), 7);
    xchk("R9 capture", int'(ext_src), 19);
    ext_level = 4'd0;
    step();
    xchk("R8 fold off at 0", int'(irq_valid), 0);
    ext_level = 4'd15;
    step();
    xchk("R8 fold off at 15", int'(irq_valid), 0);
    ext_level = 4'd7;

    // R9: held while full although pending set changes
    ext_req = 16'(1 << 1) | 16'(1 << 5);
    step();
    xchk("R9 held", int'(ext_src), 19);

    // R10/R11: acknowledge with sources still pending
    ext_ack = 1'b1;
    step();
    ext_ack = 1'b0;
    xchk("R10 cleared", int'(ext_vld), 0);
    xchk("R11 level during ack", int'(irq_level), 7);
    step();
    xchk("R10 recapture", int'(ext_src), 17);
    xchk("R11 level kept", int'(irq_level), 7);
    ext_req = '0;
    step();
    xchk("R11 level drops", int'(irq_valid), 0);
    xchk("R9 id stays", int'(ext_src), 17);

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      irq_req   = 15'($urandom) & 15'($urandom);
      cur_level = 4'($urandom);
      trap_en   = ($urandom % 8) != 0;
      ext_req   = ($urandom % 3 == 0) ? 16'($urandom) & 16'($urandom) & 16'($urandom) : '0;
      ext_level = 4'($urandom);
      ext_ack   = ($urandom % 8) == 0;
      step();
    end
    ext_ack = 1'b0;
    summary();
  end
endmodule